// File: doc/BRIEF.md
# Quadrature Decoder Timer with Write-Lock

This block turns the two phase outputs of an incremental rotary or linear encoder into a signed position count. Both phases are first retimed into the local clock. The block then decodes every edge on either phase, which gives four counts per encoder cycle. The direction of each step follows the phase order. The counter runs inside a window whose lower end is a programmable start value and whose upper end is a programmable limit. Leaving the window on either side wraps the count to the other end and sets a sticky flag. An optional power-of-two prescaler thins out the decoded steps before they reach the counter.

Software drives the block through a small 32-bit register port. Reads are combinational and writes take effect on the clock edge. A write guard protects the configuration registers. Software arms the guard by writing a 1 to a flag in the guard register. Only a 1 written to a separate release bit in the mode register lifts it again. Any write to the count register, whatever its data, reloads the start value. This gives software a way to zero the position even while the configuration is locked.

Top module: `qdec_timer`

## Requirements
- R1: After reset every register reads zero, except LIMIT (word address 2), which reads 0xFFFF. The word addresses are CTRL 0, COUNT 1, LIMIT 2, START 3, MODE 4, QCTL 5 and GUARD 6. Unmapped addresses read zero.
- R2: Taking {phase_a, phase_b} through the order 00, 01, 11, 10, 00 counts up by one on each edge. The reverse order counts down by one. The COUNT register shows the new value three clock edges after the phase input changes.
- R3: A sample in which both phases change at once is treated as illegal and leaves COUNT unchanged.
- R4: The count moves only while both MODE bit 0 (block enable) and QCTL bit 0 (decode enable) are 1. While either bit is 0, phase activity leaves COUNT unchanged.
- R5: CTRL bits [2:0] hold a value p. The counter advances once per 2^p decoded steps. Writing a different p clears the step divider, so the next 2^p steps produce the next count.
- R6: At COUNT equal to LIMIT, an up step loads START. At COUNT equal to START, a down step loads LIMIT. Each such wrap sets GUARD bit 0, which stays set until software writes a 1 to it. If a wrap and the clearing write fall in the same cycle, the flag stays set.
- R7: While the block is enabled, any write to COUNT loads the START value whatever its data. In the same cycle this reload takes priority over a counting step.
- R8: While MODE bit 0 is 0, writes to START, LIMIT and COUNT have no effect.
- R9: Writing a 1 to GUARD bit 6 arms the lock, and GUARD bit 6 then reads 1. While the lock is armed, writes to MODE, CTRL, QCTL, START and LIMIT are ignored. Writes to COUNT and GUARD still take effect.
- R10: While the lock is armed, a MODE write with bit 2 set clears the lock. None of that write's other MODE bits are applied. MODE bit 2 always reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| phase_a | input | 1 | Encoder phase A, asynchronous |
| phase_b | input | 1 | Encoder phase B, asynchronous |
| bus_addr | input | 3 | Register word address |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |

## Verification
Two pairs of events can land on the same clock edge. The first pair is a decoded step reaching the counter and a software write to COUNT. The bench provokes this by changing a phase and issuing the COUNT write exactly two edges later, so that both reach the counter together. It then judges that the start value won and that no step leaked through. The second pair is a wrap and a write that clears the flag. A behavioural reference model sees only the ports and resolves both collisions cycle by cycle. The bench compares the model with every idle read.

// File: rtl/qdec_pkg.sv
// Package: shared addresses, bit positions and types for the quadrature timer.
// Assumes a word-addressed register port with a 3-bit address.
package qdec_pkg;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] REG_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] REG_COUNT = 3'd1;
    localparam logic [ADDR_W-1:0] REG_LIMIT = 3'd2;
    localparam logic [ADDR_W-1:0] REG_START = 3'd3;
    localparam logic [ADDR_W-1:0] REG_MODE  = 3'd4;
    localparam logic [ADDR_W-1:0] REG_QCTL  = 3'd5;
    localparam logic [ADDR_W-1:0] REG_GUARD = 3'd6;

    localparam int MODE_EN_BIT     = 0;
    localparam int MODE_UNLOCK_BIT = 2;
    localparam int QCTL_EN_BIT     = 0;
    localparam int GUARD_WRAP_BIT  = 0;
    localparam int GUARD_LOCK_BIT  = 6;

    typedef struct packed {
        logic valid;
        logic up;
    } step_t;

endpackage

// File: rtl/qdec_sync.sv
// Module: multi-stage synchronizer for a bundle of asynchronous inputs.
// Assumes the inputs are level signals that are slow compared with clk.
module qdec_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First flop: sample the raw asynchronous input.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= '0;
                    else        stage_q[0] <= async_i;
                end
            end else begin : g_next
                // Later flops: give a metastable first stage time to settle.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/qdec_step.sv
// Module: x4 quadrature step decoder.
// Compares the synchronized phase pair with the previous sample. It flags a
// legal single-phase change and its direction. A change on both phases is
// rejected. Assumes the input is already synchronous to clk.
module qdec_step
    import qdec_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] ab_i,
    output step_t      step_o
);

    logic [1:0] prev_q;
    logic [1:0] diff;
    logic [1:0] pos_now;
    logic [1:0] pos_old;

    // Position of a phase pair along the Gray sequence 00,01,11,10.
    function automatic logic [1:0] gray_pos(input logic [1:0] v);
        return {v[1], v[1] ^ v[0]};
    endfunction

    // Remember the previous synchronized sample.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= ab_i;
    end

    // Decode validity (exactly one phase moved) and direction.
    always_comb begin
        diff         = ab_i ^ prev_q;
        pos_now      = gray_pos(ab_i);
        pos_old      = gray_pos(prev_q);
        step_o.valid = ^diff;
        step_o.up    = (pos_now - pos_old) == 2'd1;
    end

endmodule

// File: rtl/qdec_prescale.sv
// Module: power-of-two divider for decoded step pulses.
// Emits one tick for every 2^ps input pulses. clr restarts the division.
// Assumes ps is held stable between clears.
module qdec_prescale #(
    parameter int PS_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr_i,
    input  logic [PS_W-1:0] ps_i,
    input  logic            pulse_i,
    output logic            tick_o
);

    localparam int DIV_W = (1 << PS_W) - 1;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W:0]   ratio;
    logic [DIV_W-1:0] last_val;

    // Terminal divider value for the selected ratio.
    always_comb begin
        ratio    = (DIV_W+1)'(1) << ps_i;
        last_val = DIV_W'(ratio - (DIV_W+1)'(1));
        tick_o   = pulse_i && (div_q == last_val);
    end

    // Count pulses, restart on terminal value or on clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       div_q <= '0;
        else if (clr_i)   div_q <= '0;
        else if (tick_o)  div_q <= '0;
        else if (pulse_i) div_q <= div_q + 1'b1;
    end

endmodule

// File: rtl/qdec_timer.sv
// Module: quadrature decoder timer with a write-locked register port (top).
// Synchronizes the phase pair, decodes x4 steps, prescales them and moves a
// counter that wraps between START and LIMIT. Software access uses a 32-bit
// word port with combinational reads. Assumes one write per cycle at most.
module qdec_timer
    import qdec_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int CNT_W       = 16,
    parameter int PS_W        = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              phase_a,
    input  logic              phase_b,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);

    localparam logic [CNT_W-1:0] LIMIT_RST = {CNT_W{1'b1}};

    logic [1:0]       ab_sync;
    step_t            step_s;
    logic             cnt_pulse;
    logic             cnt_tick;
    logic             dir_up;
    logic             wrap_hit;

    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] start_q;
    logic [CNT_W-1:0] limit_q;
    logic [PS_W-1:0]  ps_q;
    logic             men_q;
    logic             qen_q;
    logic             lock_q;
    logic             wrap_q;

    logic wr_ctrl, wr_mode, wr_qctl, wr_start, wr_limit, wr_guard;
    logic cnt_reload, unlock_req, ps_change;
    logic unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:CNT_W];

    qdec_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({phase_a, phase_b}),
        .sync_o  (ab_sync)
    );

    qdec_step u_step (
        .clk    (clk),
        .rst_n  (rst_n),
        .ab_i   (ab_sync),
        .step_o (step_s)
    );

    assign cnt_pulse = step_s.valid && men_q && qen_q;
    assign dir_up    = step_s.up;

    qdec_prescale #(.PS_W(PS_W)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (ps_change),
        .ps_i    (ps_q),
        .pulse_i (cnt_pulse),
        .tick_o  (cnt_tick)
    );

    // Gate each bus write by address, lock state and block enable.
    always_comb begin
        wr_ctrl    = bus_we && (bus_addr == REG_CTRL)  && !lock_q;
        wr_mode    = bus_we && (bus_addr == REG_MODE)  && !lock_q;
        wr_qctl    = bus_we && (bus_addr == REG_QCTL)  && !lock_q;
        wr_start   = bus_we && (bus_addr == REG_START) && !lock_q && men_q;
        wr_limit   = bus_we && (bus_addr == REG_LIMIT) && !lock_q && men_q;
        wr_guard   = bus_we && (bus_addr == REG_GUARD);
        cnt_reload = bus_we && (bus_addr == REG_COUNT) && men_q;
        unlock_req = bus_we && (bus_addr == REG_MODE) && lock_q
                     && bus_wdata[MODE_UNLOCK_BIT];
        ps_change  = wr_ctrl && (bus_wdata[PS_W-1:0] != ps_q);
        wrap_hit   = cnt_tick && (dir_up ? (count_q == limit_q)
                                         : (count_q == start_q));
    end

    // Configuration registers written through the lock gate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ps_q    <= '0;
            men_q   <= 1'b0;
            qen_q   <= 1'b0;
            start_q <= '0;
            limit_q <= LIMIT_RST;
        end else begin
            if (wr_ctrl)  ps_q    <= bus_wdata[PS_W-1:0];
            if (wr_mode)  men_q   <= bus_wdata[MODE_EN_BIT];
            if (wr_qctl)  qen_q   <= bus_wdata[QCTL_EN_BIT];
            if (wr_start) start_q <= bus_wdata[CNT_W-1:0];
            if (wr_limit) limit_q <= bus_wdata[CNT_W-1:0];
        end
    end

    // Write lock: armed from GUARD, released only by the MODE release bit.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   lock_q <= 1'b0;
        else if (wr_guard && bus_wdata[GUARD_LOCK_BIT]) lock_q <= 1'b1;
        else if (unlock_req)                          lock_q <= 1'b0;
    end

    // Sticky wrap flag: a wrap wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                                     wrap_q <= 1'b0;
        else if (wrap_hit)                              wrap_q <= 1'b1;
        else if (wr_guard && bus_wdata[GUARD_WRAP_BIT]) wrap_q <= 1'b0;
    end

    // Position counter: reload beats a tick; ticks wrap inside the window.
    always_ff @(posedge clk) begin
        if (!rst_n)                  count_q <= '0;
        else if (cnt_reload)         count_q <= start_q;
        else if (cnt_tick && dir_up) count_q <= (count_q == limit_q) ? start_q : count_q + 1'b1;
        else if (cnt_tick)           count_q <= (count_q == start_q) ? limit_q : count_q - 1'b1;
    end

    // Combinational read multiplexer.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            REG_CTRL:  bus_rdata[PS_W-1:0]     = ps_q;
            REG_COUNT: bus_rdata[CNT_W-1:0]    = count_q;
            REG_LIMIT: bus_rdata[CNT_W-1:0]    = limit_q;
            REG_START: bus_rdata[CNT_W-1:0]    = start_q;
            REG_MODE:  bus_rdata[MODE_EN_BIT]  = men_q;
            REG_QCTL:  bus_rdata[QCTL_EN_BIT]  = qen_q;
            REG_GUARD: begin
                bus_rdata[GUARD_WRAP_BIT] = wrap_q;
                bus_rdata[GUARD_LOCK_BIT] = lock_q;
            end
            default:   bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/qdec_timer_chk.sv
// Module: property checker for qdec_timer, attached with bind.
// Observes the bus strobes and the top's state registers.
module qdec_timer_chk
    import qdec_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [CNT_W-1:0]  count_q,
    input logic [CNT_W-1:0]  start_q,
    input logic [CNT_W-1:0]  limit_q,
    input logic              men_q,
    input logic              qen_q,
    input logic              lock_q,
    input logic              wrap_q,
    input logic              cnt_tick,
    input logic              dir_up,
    input logic              cnt_reload
);

    a_r7_count_write_reloads: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == REG_COUNT && men_q) |=> (count_q == $past(start_q)));

    a_r4_idle_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (!(men_q && qen_q) && !(bus_we && bus_addr == REG_COUNT)) |=> $stable(count_q));

    a_r9_lock_arms: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == REG_GUARD && bus_wdata[GUARD_LOCK_BIT]) |=> lock_q);

    a_r9_locked_limit_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == REG_LIMIT && lock_q) |=> $stable(limit_q));

    a_r8_start_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == REG_START && !men_q) |=> $stable(start_q));

    a_r6_up_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_tick && dir_up && count_q == limit_q && !cnt_reload)
        |=> (count_q == $past(start_q) && wrap_q));

endmodule

bind qdec_timer qdec_timer_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .count_q    (count_q),
    .start_q    (start_q),
    .limit_q    (limit_q),
    .men_q      (men_q),
    .qen_q      (qen_q),
    .lock_q     (lock_q),
    .wrap_q     (wrap_q),
    .cnt_tick   (cnt_tick),
    .dir_up     (dir_up),
    .cnt_reload (cnt_reload)
);

// File: tb/sim_qdec_timer.sv
`timescale 1ns/1ps
// Bench: directed stimulus with a behavioural port-level reference model,
// compared on every idle cycle, plus named spot checks.
module sim_qdec_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        phase_a = 1'b0;
    logic        phase_b = 1'b0;
    logic [2:0]  bus_addr = 3'd1;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int    n_checks = 0;
    int    n_errors = 0;
    string cur_req = "R1";
    int    gpos = 0;

    always #4 clk = ~clk;

    qdec_timer u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase_a   (phase_a),
        .phase_b   (phase_b),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    // ---------------- reference model ----------------
    logic [1:0]  m_s1, m_s2, m_prev;
    int          m_div;
    logic [15:0] m_cnt, m_start, m_limit;
    logic [2:0]  m_ps;
    logic        m_men, m_qen, m_lock, m_wrap;

    logic [1:0]  t_diff;
    logic        t_step, t_up, t_tick, t_wrapped;
    int          n_div;
    logic [15:0] n_cnt, n_start, n_limit;
    logic [2:0]  n_ps;
    logic        n_men, n_qen, n_lock, n_wrap;

    function automatic int gidx(input logic [1:0] v);
        case (v)
            2'b00: return 0;
            2'b01: return 1;
            2'b11: return 2;
            default: return 3;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_prev = 0; m_div = 0;
            m_cnt = 0; m_start = 0; m_limit = 16'hFFFF; m_ps = 0;
            m_men = 0; m_qen = 0; m_lock = 0; m_wrap = 0;
        end else begin
            t_diff = m_s2 ^ m_prev;
            t_step = (t_diff == 2'b01) || (t_diff == 2'b10);
            t_up   = ((gidx(m_s2) - gidx(m_prev) + 4) % 4) == 1;
            t_tick = 0; n_div = m_div;
            if (t_step && m_men && m_qen) begin
                if (m_div == (1 << m_ps) - 1) begin t_tick = 1; n_div = 0; end
                else n_div = m_div + 1;
            end
            n_cnt = m_cnt; t_wrapped = 0;
            if (t_tick) begin
                if (t_up) begin
                    if (m_cnt == m_limit) begin n_cnt = m_start; t_wrapped = 1; end
                    else n_cnt = m_cnt + 16'd1;
                end else begin
                    if (m_cnt == m_start) begin n_cnt = m_limit; t_wrapped = 1; end
                    else n_cnt = m_cnt - 16'd1;
                end
            end
            n_start = m_start; n_limit = m_limit; n_ps = m_ps;
            n_men = m_men; n_qen = m_qen; n_lock = m_lock; n_wrap = m_wrap;
            if (bus_we) begin
                case (bus_addr)
                    3'd0: if (!m_lock) begin
                        if (bus_wdata[2:0] != m_ps) n_div = 0;
                        n_ps = bus_wdata[2:0];
                    end
                    3'd1: if (m_men) n_cnt = m_start;
                    3'd2: if (!m_lock && m_men) n_limit = bus_wdata[15:0];
                    3'd3: if (!m_lock && m_men) n_start = bus_wdata[15:0];
                    3'd4: if (m_lock) begin if (bus_wdata[2]) n_lock = 0; end
                          else n_men = bus_wdata[0];
                    3'd5: if (!m_lock) n_qen = bus_wdata[0];
                    3'd6: begin
                        if (bus_wdata[6]) n_lock = 1;
                        if (bus_wdata[0]) n_wrap = 0;
                    end
                    default: ;
                endcase
            end
            if (t_wrapped) n_wrap = 1;
            m_div = n_div; m_cnt = n_cnt; m_start = n_start; m_limit = n_limit;
            m_ps = n_ps; m_men = n_men; m_qen = n_qen; m_lock = n_lock; m_wrap = n_wrap;
            m_prev = m_s2; m_s2 = m_s1; m_s1 = {phase_a, phase_b};
        end
    end

    function automatic logic [31:0] m_read(input logic [2:0] a);
        case (a)
            3'd0: return {29'd0, m_ps};
            3'd1: return {16'd0, m_cnt};
            3'd2: return {16'd0, m_limit};
            3'd3: return {16'd0, m_start};
            3'd4: return {31'd0, m_men};
            3'd5: return {31'd0, m_qen};
            3'd6: return {25'd0, m_lock, 5'd0, m_wrap};
            default: return 32'd0;
        endcase
    endfunction

    // Compare design with model on every idle cycle, away from the edge.
    always @(negedge clk) begin
        if (rst_n && !bus_we) begin
            n_checks++;
            if (bus_rdata !== m_read(bus_addr)) begin
                n_errors++;
                $display("FAIL %s model addr=%0d actual=%h expected=%h",
                         cur_req, bus_addr, bus_rdata, m_read(bus_addr));
            end
        end
    end

    // ---------------- tasks ----------------
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(posedge clk); #2;
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #2;
        bus_we = 1'b0; bus_addr = 3'd1;
    endtask

    task automatic chk(input string tag, input logic [2:0] a, input logic [31:0] exp);
        @(posedge clk); #2;
        bus_addr = a;
        @(negedge clk);
        n_checks++;
        if (bus_rdata !== exp) begin
            n_errors++;
            $display("FAIL %s addr=%0d actual=%h expected=%h", tag, a, bus_rdata, exp);
        end
        #1 bus_addr = 3'd1;
    endtask

    task automatic set_pos(input int p);
        gpos = (p + 4) % 4;
        case (gpos)
            0: {phase_a, phase_b} = 2'b00;
            1: {phase_a, phase_b} = 2'b01;
            2: {phase_a, phase_b} = 2'b11;
            default: {phase_a, phase_b} = 2'b10;
        endcase
    endtask

    task automatic steps(input int n, input bit fwd);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #2;
            set_pos(fwd ? gpos + 1 : gpos - 1);
            repeat (4) @(posedge clk);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        n_errors++; n_checks++;
        $display("FAIL watchdog expired in %s", cur_req);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #2 rst_n = 1'b1;
        // R1: reset values
        cur_req = "R1";
        chk("R1", 3'd0, 32'h0);
        chk("R1", 3'd1, 32'h0);
        chk("R1", 3'd2, 32'h0000_FFFF);
        chk("R1", 3'd3, 32'h0);
        chk("R1", 3'd4, 32'h0);
        chk("R1", 3'd5, 32'h0);
        chk("R1", 3'd6, 32'h0);
        chk("R1", 3'd7, 32'h0);
        // R8: region writes ignored while disabled
        cur_req = "R8";
        wr(3'd3, 32'h5);
        chk("R8", 3'd3, 32'h0);
        wr(3'd2, 32'h7);
        chk("R8", 3'd2, 32'h0000_FFFF);
        // R2: forward and reverse decoding
        cur_req = "R2";
        wr(3'd4, 32'h1);
        wr(3'd5, 32'h1);
        wr(3'd3, 32'h10);
        wr(3'd1, 32'hABCD);
        chk("R7", 3'd1, 32'h10);
        steps(8, 1'b1);
        chk("R2", 3'd1, 32'h18);
        steps(3, 1'b0);
        chk("R2", 3'd1, 32'h15);
        // R3: both phases change in one sample
        cur_req = "R3";
        @(posedge clk); #2;
        {phase_a, phase_b} = ~{phase_a, phase_b};
        gpos = (gpos + 2) % 4;
        repeat (5) @(posedge clk);
        chk("R3", 3'd1, 32'h15);
        // R4: decode disabled
        cur_req = "R4";
        wr(3'd5, 32'h0);
        steps(2, 1'b1);
        chk("R4", 3'd1, 32'h15);
        wr(3'd5, 32'h1);
        // R5: prescaler and divider clear
        cur_req = "R5";
        wr(3'd0, 32'h2);
        steps(8, 1'b1);
        chk("R5", 3'd1, 32'h17);
        steps(3, 1'b1);
        wr(3'd0, 32'h1);
        steps(2, 1'b1);
        chk("R5", 3'd1, 32'h18);
        wr(3'd0, 32'h0);
        // R6: wraps and sticky flag
        cur_req = "R6";
        wr(3'd2, 32'h12);
        wr(3'd1, 32'h0);
        steps(3, 1'b1);
        chk("R6", 3'd1, 32'h10);
        chk("R6", 3'd6, 32'h1);
        wr(3'd6, 32'h1);
        chk("R6", 3'd6, 32'h0);
        steps(1, 1'b0);
        chk("R6", 3'd1, 32'h12);
        chk("R6", 3'd6, 32'h1);
        wr(3'd6, 32'h1);
        // R7: reload and a down step reach the counter together
        cur_req = "R7";
        @(posedge clk); #2;
        set_pos(gpos - 1);
        @(posedge clk);
        @(posedge clk); #2;
        bus_we = 1'b1; bus_addr = 3'd1; bus_wdata = 32'h55;
        @(posedge clk); #2;
        bus_we = 1'b0;
        repeat (3) @(posedge clk);
        chk("R7", 3'd1, 32'h10);
        chk("R7", 3'd6, 32'h0);
        // R9: lock armed
        cur_req = "R9";
        wr(3'd6, 32'h40);
        chk("R9", 3'd6, 32'h40);
        wr(3'd2, 32'h30);
        chk("R9", 3'd2, 32'h12);
        wr(3'd0, 32'h5);
        chk("R9", 3'd0, 32'h0);
        wr(3'd5, 32'h0);
        wr(3'd4, 32'h0);
        chk("R9", 3'd4, 32'h1);
        steps(1, 1'b1);
        chk("R9", 3'd1, 32'h11);
        wr(3'd1, 32'h7);
        chk("R9", 3'd1, 32'h10);
        // R10: release through the mode register
        cur_req = "R10";
        wr(3'd4, 32'h4);
        chk("R10", 3'd4, 32'h1);
        chk("R10", 3'd6, 32'h0);
        wr(3'd2, 32'h30);
        chk("R10", 3'd2, 32'h30);
        wr(3'd4, 32'h0);
        cur_req = "R4";
        steps(2, 1'b1);
        chk("R4", 3'd1, 32'h10);
        repeat (4) @(posedge clk);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule